// File: doc/BRIEF.md
# Reloadable Watchdog Timer with Write Lock

This block is a watchdog countdown timer. It is clocked from a slow tick, nominally 32 Hz. It counts down from a 6-bit timeout held in a configuration register. Software keeps the watchdog quiet by writing a kick bit, which reloads the counter and restarts the countdown. A lock bit in the same write byte decides whether that write may also change the stored timeout. Software can therefore kick the watchdog without any risk of altering the timeout. A stored timeout of zero turns the watchdog off.

When the countdown runs out, the block does two things. It raises a sticky flag, which stays set until software reads the flags. It also emits a one-clock event pulse for an interrupt controller. The tick comes from one of two places, chosen by a parameter:

- an external tick-enable input, or
- an internal prescaler that divides the 32.768 kHz clock down to 32 Hz.

After it expires, the counter rests at zero until the next kick.

Top module: `wdog_timer`

## Requirements
- R1: A write (`wr_en`=1) with bit 7 (lock) = 0 stores `wr_data[5:0]` as the timeout value.
- R2: A write with bit 7 = 1 leaves the stored timeout unchanged, whatever `wr_data[5:0]` holds.
- R3: A write with bit 6 (kick) = 1 reloads the counter with the timeout in force after that write and restarts the countdown. A kick overrides a tick that arrives in the same clock.
- R4: After a reload with timeout T > 0, `wdt_event` is high for exactly the one clock that follows the edge taking the T-th tick, and is low after every earlier tick.
- R5: A kick given before the T-th tick prevents both the event and the flag. A full T ticks are then needed from the new kick.
- R6: While the stored timeout is zero, no event and no flag are ever produced, and a running countdown is stopped.
- R7: After expiry the counter holds at zero. Further ticks produce no event until the next kick.
- R8: `wdt_flag` rises on the same clock edge as `wdt_event` and stays set until a `flag_rd` pulse. It is low in the clock after that read.
- R9: If expiry and `flag_rd` happen in the same clock, the flag stays set.
- R10: With the internal prescaler (EXT_TICK=0), one tick occurs every PRESCALE clocks, and a kick restarts the prescaler. The event therefore follows the kick edge by exactly T×PRESCALE clocks.
- R11: After reset, the timeout is zero, the counter is idle, and `wdt_flag` and `wdt_event` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock (32.768 kHz when the internal prescaler is used) |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe, one clock |
| wr_data | input | 8 | Write byte: [7] lock, [6] kick, [5:0] timeout |
| flag_rd | input | 1 | Flags-read strobe; clears the flag |
| tick_ext | input | 1 | External tick enable (used when EXT_TICK=1) |
| wdt_flag | output | 1 | Sticky timeout flag |
| wdt_event | output | 1 | One-clock timeout pulse |

## Verification
The in-RTL assertions check the following on every cycle:
- the event is one clock long and is never repeated;
- the counter is idle after an event;
- a locked write never moves the stored timeout;
- a zero timeout never leaves the countdown running;
- the flag follows its set and clear rules;
- the prescaler tick is never held high.

Other behaviour depends on a sequence of stimulus, so only the bench scenarios can show it:
- the exact tick on which expiry lands for random timeouts;
- restart after a kick at a random point;
- a kick overriding a coincident tick;
- priority of expiry over a coincident flag read;
- the T×PRESCALE clock delay through the internal prescaler.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
   localparam int unsigned WD_DATA_W   = 8;
   localparam int unsigned WD_TO_W     = 6;
   localparam int unsigned WD_KICK_BIT = 6;
   localparam int unsigned WD_LOCK_BIT = 7;
   localparam int unsigned WD_PRESCALE = 1024;

   typedef enum logic [0:0] {
      TICK_INTERNAL = 1'b0,
      TICK_EXTERNAL = 1'b1
   } wd_tick_src_e;
endpackage

// File: rtl/wdog_prescaler.sv
module wdog_prescaler #(
   parameter int unsigned DIV = 1024
) (
   input  logic clk,
   input  logic rst_n,
   input  logic restart_i,
   output logic tick_o
);
   localparam int unsigned CNT_W = (DIV > 2) ? $clog2(DIV) : 1;
   localparam logic [CNT_W-1:0] LAST = CNT_W'(DIV - 1);

   logic [CNT_W-1:0] div_q;

   assign tick_o = (div_q == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         div_q <= '0;
      end else if (restart_i || tick_o) begin
         div_q <= '0;
      end else begin
         div_q <= div_q + 1'b1;
      end
   end

   // R10
   tick_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tick_o |=> !tick_o);
endmodule

// File: rtl/wdog_cfg.sv
module wdog_cfg #(
   parameter int unsigned DATA_W   = 8,
   parameter int unsigned TO_W     = 6,
   parameter int unsigned KICK_BIT = 6,
   parameter int unsigned LOCK_BIT = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en_i,
   input  logic [DATA_W-1:0] wr_data_i,
   output logic [TO_W-1:0]   to_next_o,
   output logic              kick_o
);
   logic [TO_W-1:0] to_q;
   logic            upd;

   assign upd       = wr_en_i && !wr_data_i[LOCK_BIT];
   assign to_next_o = upd ? wr_data_i[TO_W-1:0] : to_q;
   assign kick_o    = wr_en_i && wr_data_i[KICK_BIT];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         to_q <= '0;
      end else if (upd) begin
         to_q <= wr_data_i[TO_W-1:0];
      end
   end

   // R2
   lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en_i && wr_data_i[LOCK_BIT]) |=> $stable(to_q));
   // R1
   unlocked_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en_i && !wr_data_i[LOCK_BIT]) |=> (to_q == $past(wr_data_i[TO_W-1:0])));
endmodule

// File: rtl/wdog_count.sv
module wdog_count #(
   parameter int unsigned TO_W = 6
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            tick_i,
   input  logic            kick_i,
   input  logic [TO_W-1:0] load_i,
   output logic            fire_o,
   output logic            event_o
);
   localparam logic [TO_W-1:0] ONE = TO_W'(1);

   logic [TO_W-1:0] cnt_q;
   logic            run_q;
   logic            evt_q;
   logic            zero_to;

   assign zero_to = (load_i == '0);
   assign fire_o  = run_q && tick_i && !kick_i && !zero_to && (cnt_q == ONE);
   assign event_o = evt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         run_q <= 1'b0;
         evt_q <= 1'b0;
      end else begin
         evt_q <= fire_o;
         if (kick_i && !zero_to) begin
            cnt_q <= load_i;
            run_q <= 1'b1;
         end else if (zero_to) begin
            cnt_q <= '0;
            run_q <= 1'b0;
         end else if (run_q && tick_i) begin
            cnt_q <= cnt_q - 1'b1;
            if (cnt_q == ONE) run_q <= 1'b0;
         end
      end
   end

   // R4
   event_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      evt_q |=> !evt_q);
   // R7
   idle_after_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
      evt_q |-> (!run_q && cnt_q == '0));
   // R6
   zero_stops_chk: assert property (@(posedge clk) disable iff (!rst_n)
      zero_to |=> !run_q);
endmodule

// File: rtl/wdog_flag.sv
module wdog_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic rd_i,
   output logic flag_o
);
   logic flag_q;

   assign flag_o = flag_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flag_q <= 1'b0;
      else        flag_q <= set_i || (flag_q && !rd_i);
   end

   // R8
   flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_i && !set_i) |=> !flag_q);
   // R9
   flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      set_i |=> flag_q);
endmodule

// File: rtl/wdog_timer.sv
module wdog_timer #(
   parameter int unsigned DATA_W   = wdog_pkg::WD_DATA_W,
   parameter int unsigned TO_W     = wdog_pkg::WD_TO_W,
   parameter int unsigned KICK_BIT = wdog_pkg::WD_KICK_BIT,
   parameter int unsigned LOCK_BIT = wdog_pkg::WD_LOCK_BIT,
   parameter int unsigned PRESCALE = wdog_pkg::WD_PRESCALE,
   parameter bit          EXT_TICK = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              flag_rd,
   input  logic              tick_ext,
   output logic              wdt_flag,
   output logic              wdt_event
);
   localparam wdog_pkg::wd_tick_src_e TICK_SRC =
      EXT_TICK ? wdog_pkg::TICK_EXTERNAL : wdog_pkg::TICK_INTERNAL;

   if (TO_W < 1 || TO_W > KICK_BIT || TO_W > LOCK_BIT)
      $fatal(1, "timeout field overlaps control bits");
   if (KICK_BIT >= DATA_W || LOCK_BIT >= DATA_W || KICK_BIT == LOCK_BIT)
      $fatal(1, "control bit positions invalid");
   if (PRESCALE < 2)
      $fatal(1, "prescale must be at least 2");

   logic [TO_W-1:0] to_next;
   logic            kick;
   logic            tick;
   logic            fire;

   wdog_cfg #(
      .DATA_W(DATA_W), .TO_W(TO_W), .KICK_BIT(KICK_BIT), .LOCK_BIT(LOCK_BIT)
   ) u_cfg (
      .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .wr_data_i(wr_data),
      .to_next_o(to_next), .kick_o(kick)
   );

   if (TICK_SRC == wdog_pkg::TICK_EXTERNAL) begin : g_ext_tick
      assign tick = tick_ext;
   end else begin : g_int_tick
      logic unused_tick_ext;
      assign unused_tick_ext = tick_ext;
      wdog_prescaler #(.DIV(PRESCALE)) u_pre (
         .clk(clk), .rst_n(rst_n), .restart_i(kick), .tick_o(tick)
      );
   end

   wdog_count #(.TO_W(TO_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .tick_i(tick), .kick_i(kick),
      .load_i(to_next), .fire_o(fire), .event_o(wdt_event)
   );

   wdog_flag u_flag (
      .clk(clk), .rst_n(rst_n), .set_i(fire), .rd_i(flag_rd), .flag_o(wdt_flag)
   );

   // R8
   event_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wdt_event |-> wdt_flag);
   // R8
   flag_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(wdt_flag) |-> wdt_event);
endmodule

// File: tb/wdog_timer_bench.sv
`timescale 1ns/1ps
module wdog_timer_bench;
   localparam int unsigned PRE = 4;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic [7:0] wr_data = 8'h00;
   logic       flag_rd = 1'b0;
   logic       tick_ext = 1'b0;
   logic       wdt_flag, wdt_event, p_flag, p_event;

   int checks = 0;
   int errors = 0;
   int cyc = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   wdog_timer #(.EXT_TICK(1'b1)) u_wdog_timer (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
      .flag_rd(flag_rd), .tick_ext(tick_ext),
      .wdt_flag(wdt_flag), .wdt_event(wdt_event)
   );

   wdog_timer #(.EXT_TICK(1'b0), .PRESCALE(PRE)) u_wdog_timer_pre (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
      .flag_rd(flag_rd), .tick_ext(1'b0),
      .wdt_flag(p_flag), .wdt_event(p_event)
   );

   function automatic bit exp_event(int n, int t);
      return (t != 0) && (n == t);
   endfunction

   function automatic logic [7:0] wbyte(bit lock, bit kick, logic [5:0] to);
      return {lock, kick, to};
   endfunction

   task automatic chk(logic act, logic exp, string tag);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
      end
   endtask

   task automatic wr(logic [7:0] d);
      wr_data = d; wr_en = 1'b1;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic tick();
      tick_ext = 1'b1;
      @(negedge clk);
      tick_ext = 1'b0;
   endtask

   task automatic rd();
      flag_rd = 1'b1;
      @(negedge clk);
      flag_rd = 1'b0;
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000 && !done) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd4711));
      repeat (3) @(negedge clk);
      // R11: reset state
      chk(wdt_flag, 1'b0, "R11 flag after reset");
      chk(wdt_event, 1'b0, "R11 event after reset");
      rst_n = 1'b1;
      @(negedge clk);
      // R11 / R6: timeout zero after reset, ticks do nothing
      for (int i = 0; i < 70; i++) begin
         tick();
         chk(wdt_event, 1'b0, "R11 no event with reset timeout");
      end
      chk(wdt_flag, 1'b0, "R11 no flag with reset timeout");

      // R10: prescaled instance, T=5 -> event after 20 clocks
      wr(wbyte(1'b0, 1'b1, 6'd5));
      for (int i = 1; i <= 5 * PRE; i++) begin
         @(negedge clk);
         if (i >= 5 * PRE - 1)
            chk(p_event, (i == 5 * PRE), "R10 prescaled expiry timing");
      end
      chk(p_flag, 1'b1, "R10 prescaled flag");
      rd();

      // R1 R3 R4 R8: directed T=3
      wr(wbyte(1'b0, 1'b1, 6'd3));
      for (int n = 1; n <= 3; n++) begin
         tick();
         chk(wdt_event, exp_event(n, 3), "R4 event timing T=3");
         chk(wdt_flag, exp_event(n, 3), "R8 flag with event");
      end
      @(negedge clk);
      chk(wdt_event, 1'b0, "R4 event one clock");
      chk(wdt_flag, 1'b1, "R8 flag sticky");
      // R7
      for (int i = 0; i < 5; i++) begin
         tick();
         chk(wdt_event, 1'b0, "R7 no event after expiry");
      end
      rd();
      chk(wdt_flag, 1'b0, "R8 flag cleared by read");

      // R2: locked write keeps timeout 3
      wr(wbyte(1'b1, 1'b1, 6'd40));
      for (int n = 1; n <= 3; n++) begin
         tick();
         chk(wdt_event, exp_event(n, 3), "R2 lock keeps timeout");
      end
      rd();

      // R3: kick overrides a coincident tick
      wr(wbyte(1'b0, 1'b1, 6'd3));
      tick(); tick();
      tick_ext = 1'b1;
      wr(wbyte(1'b1, 1'b1, 6'd0));
      tick_ext = 1'b0;
      chk(wdt_event, 1'b0, "R3 kick beats tick");
      for (int n = 1; n <= 3; n++) begin
         tick();
         chk(wdt_event, exp_event(n, 3), "R3 full reload after kick");
      end
      rd();

      // R9: expiry and read in the same clock
      wr(wbyte(1'b0, 1'b1, 6'd2));
      tick();
      tick_ext = 1'b1; flag_rd = 1'b1;
      @(negedge clk);
      tick_ext = 1'b0; flag_rd = 1'b0;
      chk(wdt_event, 1'b1, "R9 event on coincident read");
      chk(wdt_flag, 1'b1, "R9 set wins over read");
      rd();
      chk(wdt_flag, 1'b0, "R9 later read clears");

      // R5: random timeouts with a kick before expiry
      for (int it = 0; it < 12; it++) begin
         int t;
         int k;
         t = $urandom_range(2, 63);
         k = $urandom_range(1, t - 1);
         wr(wbyte(1'b0, 1'b1, 6'(t)));
         for (int n = 1; n <= k; n++) begin
            tick();
            if (wdt_event !== 1'b0) chk(wdt_event, 1'b0, "R5 early event");
         end
         wr(wbyte(1'b1, 1'b1, 6'($urandom_range(0, 63))));
         for (int n = 1; n <= t; n++) begin
            tick();
            if (n >= t - 1) chk(wdt_event, exp_event(n, t), "R5 event after rekick");
            else if (wdt_event !== 1'b0) chk(wdt_event, 1'b0, "R5 early event");
         end
         rd();
      end

      // R6: zero timeout written while running stops it
      wr(wbyte(1'b0, 1'b1, 6'd4));
      tick();
      wr(wbyte(1'b0, 1'b0, 6'd0));
      for (int i = 0; i < 70; i++) begin
         tick();
         if (wdt_event !== 1'b0) chk(wdt_event, 1'b0, "R6 zero disables");
      end
      wr(wbyte(1'b1, 1'b1, 6'd9));
      for (int i = 0; i < 10; i++) tick();
      chk(wdt_flag, 1'b0, "R6 kick with zero timeout no flag");

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule